// File: doc/BRIEF.md
# Privileged Control Register Bank

This block is a small set of privileged control registers for a simple processor core. Software reaches it through a single-cycle port that carries a register index, a write enable, write data and read data. Reads are combinational from the current state. Writes take effect at the next clock edge. Any exception that an access raises is reported as a one-cycle pulse in the cycle after the access.

Hardware and software share the bank. The memory unit can load a faulting address into a read-only slot. One register carries a paging-enable flag. Another holds a translation table base and, when a flag in a third register allows it, a context tag in its low bits. Those views are exported as separate outputs for the translation logic. A task-priority register keeps only four meaningful bits and refuses writes that set any of its reserved bits. Indices with no register behind them trap as undefined operations. Translation itself, exception delivery and any extended register space belong to other blocks.

Top module: `cr_bank`

## Requirements
- R1: After reset every implemented register reads zero (indices 0, 2, 3, 4 and 8), and pg_base, pg_base_vld and ctx_tag are zero.
- R2: An access (read or write) to index 1, 5, 6, 7 or any index from 9 to 15 raises undef_pulse for exactly the following cycle, returns rd_data of zero, and changes no register.
- R3: When fault_vld is high at a clock edge, index 2 takes fault_addr at that edge, even if software writes index 2 in the same cycle.
- R4: Index 2 is read-only: a software write to it changes nothing and raises no exception.
- R5: pg_base always equals bits 31:12 of index 3. pg_base_vld is high exactly while bit 31 of index 0 (paging enable) is set.
- R6: While bit 17 of index 4 (context-tag enable) is set, ctx_tag equals bits 11:0 of index 3. Otherwise ctx_tag is zero.
- R7: Index 8 stores a 4-bit priority in bits 3:0. A write whose bits 31:4 are all zero is stored. A write with any of those bits set is refused: the register keeps its old value and prot_pulse is high for the following cycle.
- R8: A read returns, in the same cycle, the value that the last accepted write or fault load left in the selected register.
- R9: undef_pulse and prot_pulse are never high together, and each falls in the cycle after an access that raises no exception.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_en | input | 1 | An access is presented this cycle |
| acc_we | input | 1 | The access is a write |
| acc_idx | input | 4 | Register index |
| acc_wdata | input | 32 | Write data |
| rd_data | output | 32 | Read data of the indexed register (zero for trapping indices) |
| fault_vld | input | 1 | The memory unit reports a page fault |
| fault_addr | input | 32 | Faulting linear address |
| undef_pulse | output | 1 | Undefined-operation exception, one cycle after the access |
| prot_pulse | output | 1 | Protection exception on a refused priority write |
| pg_base | output | 20 | Translation table base |
| pg_base_vld | output | 1 | Paging enabled, so pg_base is meaningful |
| ctx_tag | output | 12 | Process-context tag, or zero when disabled |

## Verification
A corrupted register shows up in two places. The next read of that index shows it on rd_data in the same cycle. Registers 0, 3 and 4 also show it at once on pg_base, pg_base_vld or ctx_tag, with no access needed. A trap that wrongly writes state shows up on the first later read of the register it touched. A wrongly accepted priority write shows up two ways: prot_pulse stays low, and index 8 holds bits above bit 3. A missing or stuck fault load is visible on the first read of index 2 after the fault edge.

// File: rtl/cr_pkg.sv
package cr_pkg;
    localparam int XLEN    = 32;
    localparam int IDX_W   = 4;
    localparam int PRIO_W  = 4;
    localparam int CTX_W   = 12;
    localparam int BASE_W  = XLEN - CTX_W;

    typedef enum logic [2:0] {
        AK_NONE,
        AK_RSV,
        AK_MODE,
        AK_FAULT,
        AK_BASE,
        AK_FEAT,
        AK_PRIO
    } acc_kind_e;

    typedef struct packed {
        logic [XLEN-1:0] mode;
        logic [XLEN-1:0] fault;
        logic [XLEN-1:0] base;
        logic [XLEN-1:0] feat;
        logic [XLEN-1:0] prio;
    } cr_state_t;

    function automatic logic prio_ok(input logic [XLEN-1:0] d);
        return d[XLEN-1:PRIO_W] == '0;
    endfunction
endpackage

// File: rtl/cr_idx_decode.sv
module cr_idx_decode
    import cr_pkg::*;
(
    input  logic             en,
    input  logic [IDX_W-1:0] idx,
    output acc_kind_e        kind
);
    always_comb begin
        kind = AK_NONE;
        if (en) begin
            case (idx)
                IDX_W'(0): kind = AK_MODE;
                IDX_W'(2): kind = AK_FAULT;
                IDX_W'(3): kind = AK_BASE;
                IDX_W'(4): kind = AK_FEAT;
                IDX_W'(8): kind = AK_PRIO;
                default:   kind = AK_RSV;
            endcase
        end
    end
endmodule

// File: rtl/cr_prio_check.sv
module cr_prio_check
    import cr_pkg::*;
(
    input  logic [XLEN-1:0] wdata,
    output logic            legal
);
    assign legal = prio_ok(wdata);
endmodule

// File: rtl/cr_xlat_view.sv
module cr_xlat_view
    import cr_pkg::*;
(
    input  logic              pg_en,
    input  logic              cid_en,
    input  logic [XLEN-1:0]   base_reg,
    output logic [BASE_W-1:0] pg_base,
    output logic              pg_base_vld,
    output logic [CTX_W-1:0]  ctx_tag
);
    assign pg_base     = base_reg[XLEN-1:CTX_W];
    assign pg_base_vld = pg_en;
    assign ctx_tag     = cid_en ? base_reg[CTX_W-1:0] : '0;
endmodule

// File: rtl/cr_bank.sv
module cr_bank
    import cr_pkg::*;
#(
    parameter int PG_BIT  = 31,
    parameter int CID_BIT = 17
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              acc_en,
    input  logic              acc_we,
    input  logic [IDX_W-1:0]  acc_idx,
    input  logic [XLEN-1:0]   acc_wdata,
    output logic [XLEN-1:0]   rd_data,
    input  logic              fault_vld,
    input  logic [XLEN-1:0]   fault_addr,
    output logic              undef_pulse,
    output logic              prot_pulse,
    output logic [BASE_W-1:0] pg_base,
    output logic              pg_base_vld,
    output logic [CTX_W-1:0]  ctx_tag
);
    acc_kind_e kind;
    logic      wr_legal;
    cr_state_t st;

    cr_idx_decode u_dec (.en(acc_en), .idx(acc_idx), .kind(kind));
    cr_prio_check u_chk (.wdata(acc_wdata), .legal(wr_legal));
    cr_xlat_view  u_view (
        .pg_en       (st.mode[PG_BIT]),
        .cid_en      (st.feat[CID_BIT]),
        .base_reg    (st.base),
        .pg_base     (pg_base),
        .pg_base_vld (pg_base_vld),
        .ctx_tag     (ctx_tag)
    );

    always_comb begin
        case (kind)
            AK_MODE:  rd_data = st.mode;
            AK_FAULT: rd_data = st.fault;
            AK_BASE:  rd_data = st.base;
            AK_FEAT:  rd_data = st.feat;
            AK_PRIO:  rd_data = st.prio;
            default:  rd_data = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st          <= '0;
            undef_pulse <= 1'b0;
            prot_pulse  <= 1'b0;
        end else begin
            undef_pulse <= (kind == AK_RSV);
            prot_pulse  <= acc_we && (kind == AK_PRIO) && !wr_legal;
            if (acc_we) begin
                case (kind)
                    AK_MODE: st.mode <= acc_wdata;
                    AK_BASE: st.base <= acc_wdata;
                    AK_FEAT: st.feat <= acc_wdata;
                    AK_PRIO: if (wr_legal) st.prio <= acc_wdata;
                    default: ;
                endcase
            end
            if (fault_vld) st.fault <= fault_addr;
        end
    end

    // R2: a trapping access leaves every software-writable register alone
    p_undef_hold_r2: assert property (@(posedge clk) disable iff (rst)
        undef_pulse |-> ($stable(st.mode) && $stable(st.base) &&
                         $stable(st.feat) && $stable(st.prio)));

    // R3: fault address lands in index 2 at the fault edge
    p_fault_load_r3: assert property (@(posedge clk) disable iff (rst)
        fault_vld |=> (st.fault == $past(fault_addr)));

    // R4: without a fault, index 2 never moves
    p_fault_ro_r4: assert property (@(posedge clk) disable iff (rst)
        !fault_vld |=> $stable(st.fault));

    // R5: the valid flag follows the paging-enable bit
    p_base_vld_r5: assert property (@(posedge clk) disable iff (rst)
        pg_base_vld == st.mode[PG_BIT]);

    // R7: reserved priority bits stay zero, refused writes leave the value
    p_prio_rsv_r7: assert property (@(posedge clk) disable iff (rst)
        st.prio[XLEN-1:PRIO_W] == '0);
    p_prot_hold_r7: assert property (@(posedge clk) disable iff (rst)
        prot_pulse |-> $stable(st.prio));

    // R9: the two exception pulses are exclusive
    p_excl_r9: assert property (@(posedge clk) disable iff (rst)
        !(undef_pulse && prot_pulse));
endmodule

// File: tb/test_cr_bank.sv
`timescale 1ns/1ps
module test_cr_bank;
    import cr_pkg::*;

    localparam int SEL_RD = 0, SEL_UD = 1, SEL_GP = 2, SEL_BASE = 3, SEL_BVLD = 4, SEL_CTX = 5;

    typedef struct {
        int          sel;
        logic [31:0] exp;
        string       req;
    } item_t;

    logic              clk = 0;
    logic              rst = 1;
    logic              acc_en = 0, acc_we = 0;
    logic [IDX_W-1:0]  acc_idx = '0;
    logic [XLEN-1:0]   acc_wdata = '0;
    logic [XLEN-1:0]   rd_data;
    logic              fault_vld = 0;
    logic [XLEN-1:0]   fault_addr = '0;
    logic              undef_pulse, prot_pulse;
    logic [BASE_W-1:0] pg_base;
    logic              pg_base_vld;
    logic [CTX_W-1:0]  ctx_tag;

    int    n_checks = 0;
    int    n_fail   = 0;
    bit    done     = 0;
    item_t sb[$];

    always #2 clk = ~clk;

    cr_bank i_cr_bank (
        .clk(clk), .rst(rst), .acc_en(acc_en), .acc_we(acc_we), .acc_idx(acc_idx),
        .acc_wdata(acc_wdata), .rd_data(rd_data), .fault_vld(fault_vld),
        .fault_addr(fault_addr), .undef_pulse(undef_pulse), .prot_pulse(prot_pulse),
        .pg_base(pg_base), .pg_base_vld(pg_base_vld), .ctx_tag(ctx_tag)
    );

    function automatic logic [31:0] observe(int sel);
        case (sel)
            SEL_RD:   return rd_data;
            SEL_UD:   return {31'd0, undef_pulse};
            SEL_GP:   return {31'd0, prot_pulse};
            SEL_BASE: return {12'd0, pg_base};
            SEL_BVLD: return {31'd0, pg_base_vld};
            default:  return {20'd0, ctx_tag};
        endcase
    endfunction

    // monitor: samples 1 ns after each rising edge
    initial begin
        forever begin
            @(posedge clk);
            #1;
            while (sb.size() > 0) begin
                item_t it;
                logic [31:0] act;
                it  = sb.pop_front();
                act = observe(it.sel);
                n_checks++;
                if (act !== it.exp) begin
                    n_fail++;
                    $display("FAIL %s sel=%0d actual=%h expected=%h", it.req, it.sel, act, it.exp);
                end
            end
        end
    end

    task automatic expect_out(int sel, logic [31:0] e, string req);
        item_t it;
        it.sel = sel; it.exp = e; it.req = req;
        sb.push_back(it);
    endtask

    // driver: applies one cycle of stimulus at the falling edge
    task automatic step(logic en, logic we, logic [3:0] idx, logic [31:0] wd,
                        logic pf, logic [31:0] pa);
        @(negedge clk);
        acc_en = en; acc_we = we; acc_idx = idx; acc_wdata = wd;
        fault_vld = pf; fault_addr = pa;
    endtask

    task automatic wr(logic [3:0] idx, logic [31:0] wd);
        step(1, 1, idx, wd, 0, 0);
    endtask

    task automatic rd(logic [3:0] idx, logic [31:0] e, string req);
        step(1, 0, idx, 0, 0, 0);
        expect_out(SEL_RD, e, req);
    endtask

    task automatic idle();
        step(0, 0, 0, 0, 0, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        // R1 reset state
        rd(0, 0, "R1");
        expect_out(SEL_BASE, 0, "R1");
        expect_out(SEL_BVLD, 0, "R1");
        expect_out(SEL_CTX, 0, "R1");
        rd(2, 0, "R1");
        rd(3, 0, "R1");
        rd(4, 0, "R1");
        rd(8, 0, "R1");
        // R8 / R5 base register and translation view
        wr(3, 32'hABCDE123);
        rd(3, 32'hABCDE123, "R8");
        expect_out(SEL_BASE, 32'h000ABCDE, "R5");
        expect_out(SEL_BVLD, 0, "R5");
        wr(0, 32'h8000_0000);
        idle();
        expect_out(SEL_BVLD, 1, "R5");
        expect_out(SEL_CTX, 0, "R6");
        // R6 context tag enable
        wr(4, 32'h0002_0000);
        idle();
        expect_out(SEL_CTX, 32'h123, "R6");
        wr(4, 32'h0000_0000);
        idle();
        expect_out(SEL_CTX, 0, "R6");
        wr(4, 32'h0002_0000);
        // R2 trapping indices
        wr(5, 32'hFFFF_FFFF);
        expect_out(SEL_UD, 1, "R2");
        expect_out(SEL_RD, 0, "R2");
        rd(0, 32'h8000_0000, "R2");
        expect_out(SEL_UD, 0, "R9");
        step(1, 0, 1, 0, 0, 0);
        expect_out(SEL_UD, 1, "R2");
        expect_out(SEL_RD, 0, "R2");
        step(1, 1, 12, 32'h0, 0, 0);
        expect_out(SEL_UD, 1, "R2");
        expect_out(SEL_GP, 0, "R9");
        wr(7, 32'h0000_0000);
        expect_out(SEL_UD, 1, "R2");
        idle();
        expect_out(SEL_UD, 0, "R9");
        expect_out(SEL_CTX, 32'h123, "R2");
        expect_out(SEL_BVLD, 1, "R2");
        rd(4, 32'h0002_0000, "R2");
        rd(3, 32'hABCDE123, "R2");
        // R3 fault load wins over a same-cycle write
        step(1, 1, 2, 32'h1111_1111, 1, 32'hDEAD_B000);
        expect_out(SEL_UD, 0, "R3");
        rd(2, 32'hDEAD_B000, "R3");
        // R4 software write ignored
        wr(2, 32'h5555_5555);
        expect_out(SEL_UD, 0, "R4");
        expect_out(SEL_GP, 0, "R4");
        rd(2, 32'hDEAD_B000, "R4");
        step(0, 0, 0, 0, 1, 32'h0040_2ABC);
        rd(2, 32'h0040_2ABC, "R3");
        // R7 priority register
        wr(8, 32'h9);
        expect_out(SEL_GP, 0, "R7");
        rd(8, 32'h9, "R7");
        wr(8, 32'h19);
        expect_out(SEL_GP, 1, "R7");
        expect_out(SEL_UD, 0, "R9");
        rd(8, 32'h9, "R7");
        expect_out(SEL_GP, 0, "R9");
        wr(8, 32'h8000_0000);
        expect_out(SEL_GP, 1, "R7");
        wr(8, 32'hF);
        expect_out(SEL_GP, 0, "R7");
        rd(8, 32'hF, "R7");
        // R1 reset clears everything again
        @(negedge clk);
        rst = 1;
        acc_en = 0; acc_we = 0;
        @(negedge clk);
        rst = 0;
        rd(8, 0, "R1");
        expect_out(SEL_CTX, 0, "R1");
        expect_out(SEL_BVLD, 0, "R1");
        rd(2, 0, "R1");
        idle();
        idle();
        done = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end
endmodule